// File: doc/BRIEF.md
# Edge-window TDC fine-time encoder

This block turns the sampled taps of a tapped delay line into edge timestamps. Each clock it registers one snapshot of the line. When the tap nearest the line input has left the line's settled level, an edge has entered. The block then finds where the step sits along the line and keeps only a 32-tap window around it. The rest of the snapshot is dropped.

The window is turned into a fine code by counting the taps that hold the new level, which tolerates bubbles. A calibration table maps the code to a time value, and that value is subtracted from the scaled coarse count latched when the snapshot was taken. The same channel handles rising and falling steps. Each output is tagged with its polarity, and every falling-step timestamp comes with the pulse width measured from the rising step before it.

Calibration entries are loaded through a simple write port before or between measurements. The delay line, its placement and the hit-reshaping register that drives it are outside this block; the line is an input vector here.

Top module: `tdcFineEncoder`

## Requirements
- R1: A snapshot whose tap 0 differs from the current line level is an edge. A new level of 1 is a leading edge, reported with `tsLead`=1; a new level of 0 is a trailing edge, reported with `tsLead`=0. After reset the level is 0, so the first report is leading and the reports then alternate.
- R2: For a clean step where taps 0..k-1 hold the new level and the rest hold the old level, the fine code is k. The timestamp is `coarse*CLK_UNITS - cal[k]` modulo 2^TW. `coarse` is the free-running counter value when the snapshot was registered; that counter is 0 on the cycle reset is released and adds 1 per clock.
- R3: A bubble pair inside the transition does not change the fine code. The pair is tap k-2 at the old level and tap k+1 at the new level.
- R4: The window is clamped to the line. An edge with k=1 gives code 1, and a snapshot with every tap at the new level gives code TAPS.
- R5: A timestamp appears for exactly one cycle, on the fifth clock edge after the edge at which the snapshot was registered. No other cycle shows `tsValid`.
- R6: With each trailing timestamp, `totValid` is high and `totWidth` equals trailing time minus the preceding leading time, modulo 2^TW. `totValid` is never high with a leading timestamp.
- R7: Edges in consecutive snapshots are each timestamped, so dead time is one clock.
- R8: A calibration write to entry a sets the value used for later edges with code a.
- R9: During and right after reset, `tsValid` and `totValid` are low.
- R10: A snapshot whose tap 0 equals the current level produces no output, whatever its other taps hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the delay line |
| rst | input | 1 | Synchronous reset, active high |
| tapsIn | input | TAPS | Delay-line snapshot, tap 0 nearest the line input |
| calWe | input | 1 | Calibration table write enable |
| calAddr | input | FCW | Calibration entry index (fine code) |
| calData | input | CALW | Calibration value for that code |
| tsValid | output | 1 | One-cycle timestamp strobe |
| tsLead | output | 1 | 1 for a leading edge, 0 for a trailing edge |
| tsTime | output | TW | Edge timestamp |
| totValid | output | 1 | Pulse-width strobe, set with trailing timestamps |
| totWidth | output | TW | Trailing minus leading time |

## Verification
Every snapshot the bench drives is tagged with a due cycle six counts of its own clock counter after the drive. That covers the sampling register, the locate, slice, encode and table-read stages, and the output register. On every clock the bench samples the outputs at the falling edge and compares them with what the model booked for that cycle. Cycles with nothing booked must show both strobes low. The pulse width is checked in the same cycle as the trailing timestamp. This means a shifted, stretched or missing strobe is reported against the snapshot that caused it.

// File: rtl/tdcPkg.sv
package tdcPkg;
  // stage enables issued by the control to the datapath
  typedef struct packed {
    logic locate;
    logic slice;
    logic encode;
    logic lookup;
    logic emit;
  } tdcStb_t;
endpackage

// File: rtl/tdcCtl.sv
module tdcCtl
  import tdcPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hit,
  output tdcStb_t stb
);
  localparam int STAGES = 4;

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[STAGES-2:0], hit};
  end

  assign stb = '{locate: hit, slice: vPipe[0], encode: vPipe[1],
                 lookup: vPipe[2], emit: vPipe[3]};
endmodule

// File: rtl/tdcDp.sv
module tdcDp
  import tdcPkg::*;
#(
  parameter int TAPS      = 64,
  parameter int WIN       = 32,
  parameter int CW        = 16,
  parameter int CALW      = 16,
  parameter int TW        = 32,
  parameter int CLK_UNITS = 5000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [TAPS-1:0]               tapsIn,
  input  logic                          calWe,
  input  logic [$clog2(TAPS+1)-1:0]     calAddr,
  input  logic [CALW-1:0]               calData,
  input  tdcStb_t                       stb,
  output logic                          hit,
  output logic                          tsValid,
  output logic                          tsLead,
  output logic [TW-1:0]                 tsTime,
  output logic                          totValid,
  output logic [TW-1:0]                 totWidth
);
  localparam int FCW       = $clog2(TAPS + 1);
  localparam int SW        = $clog2(TAPS - WIN + 1);
  localparam int WIN_LEAD  = WIN / 8;
  localparam int LUT_DEPTH = 1 << FCW;

  logic [TAPS-1:0] sampleQ, sample2Q;
  logic [CW-1:0]   cnt, snapQ, c1Q, c2Q, c3Q, c4Q;
  logic            level, p1Q, p2Q, p3Q, p4Q;
  logic [FCW-1:0]  firstOld, fineQ;
  logic [SW-1:0]   startNext, startQ, start2Q;
  logic [WIN-1:0]  winQ, newMask;
  logic [CALW-1:0] calMem [LUT_DEPTH];
  logic [CALW-1:0] lutQ;
  logic [TW-1:0]   edgeTime, leadQ;
  int              sInt;

  // snapshot and coarse count
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      snapQ   <= '0;
      sampleQ <= '0;
      level   <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      snapQ   <= cnt;
      sampleQ <= tapsIn;
      if (stb.locate) level <= sampleQ[0];
    end
  end

  assign hit = (sampleQ[0] != level);

  // lowest tap still at the old level
  always_comb begin
    firstOld = FCW'(TAPS);
    for (int i = TAPS - 1; i >= 0; i--)
      if (sampleQ[i] == level) firstOld = FCW'(i);
  end

  always_comb begin
    sInt = int'(firstOld) - WIN_LEAD;
    if (sInt < 0) sInt = 0;
    if (sInt > TAPS - WIN) sInt = TAPS - WIN;
    startNext = SW'(sInt);
  end

  assign newMask = p2Q ? winQ : ~winQ;

  // pipeline stages, each enabled by its strobe
  always_ff @(posedge clk) begin
    if (stb.locate) begin
      sample2Q <= sampleQ;
      startQ   <= startNext;
      p1Q      <= sampleQ[0];
      c1Q      <= snapQ;
    end
    if (stb.slice) begin
      winQ    <= WIN'(sample2Q >> startQ);
      start2Q <= startQ;
      p2Q     <= p1Q;
      c2Q     <= c1Q;
    end
    if (stb.encode) begin
      fineQ <= FCW'(start2Q) + FCW'($countones(newMask));
      p3Q   <= p2Q;
      c3Q   <= c2Q;
    end
    if (calWe) calMem[calAddr] <= calData;
    if (stb.lookup) begin
      lutQ <= calMem[fineQ];
      p4Q  <= p3Q;
      c4Q  <= c3Q;
    end
  end

  assign edgeTime = TW'(c4Q) * TW'(CLK_UNITS) - TW'(lutQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      tsValid  <= 1'b0;
      totValid <= 1'b0;
      tsLead   <= 1'b0;
      tsTime   <= '0;
      totWidth <= '0;
      leadQ    <= '0;
    end else begin
      tsValid  <= stb.emit;
      totValid <= stb.emit & ~p4Q;
      if (stb.emit) begin
        tsTime <= edgeTime;
        tsLead <= p4Q;
        if (p4Q) leadQ    <= edgeTime;
        else     totWidth <= edgeTime - leadQ;
      end
    end
  end
endmodule

// File: rtl/tdcFineEncoder.sv
module tdcFineEncoder
  import tdcPkg::*;
#(
  parameter int TAPS      = 64,
  parameter int WIN       = 32,
  parameter int CW        = 16,
  parameter int CALW      = 16,
  parameter int TW        = 32,
  parameter int CLK_UNITS = 5000,
  localparam int FCW      = $clog2(TAPS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAPS-1:0] tapsIn,
  input  logic            calWe,
  input  logic [FCW-1:0]  calAddr,
  input  logic [CALW-1:0] calData,
  output logic            tsValid,
  output logic            tsLead,
  output logic [TW-1:0]   tsTime,
  output logic            totValid,
  output logic [TW-1:0]   totWidth
);
  tdcStb_t stb;
  logic    hit;

  tdcCtl ctl_i (.clk(clk), .rst(rst), .hit(hit), .stb(stb));

  tdcDp #(
    .TAPS(TAPS), .WIN(WIN), .CW(CW), .CALW(CALW), .TW(TW), .CLK_UNITS(CLK_UNITS)
  ) dp_i (
    .clk(clk), .rst(rst), .tapsIn(tapsIn),
    .calWe(calWe), .calAddr(calAddr), .calData(calData),
    .stb(stb), .hit(hit),
    .tsValid(tsValid), .tsLead(tsLead), .tsTime(tsTime),
    .totValid(totValid), .totWidth(totWidth)
  );
endmodule

// File: rtl/tdcFineEncoderChk.sv
module tdcFineEncoderChk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          locateStb,
  input logic          tsValid,
  input logic          tsLead,
  input logic [TW-1:0] tsTime,
  input logic          totValid,
  input logic [TW-1:0] totWidth
);
  logic          seenAny, lastLead;
  logic [TW-1:0] leadHeld;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenAny  <= 1'b0;
      lastLead <= 1'b0;
      leadHeld <= '0;
    end else if (tsValid) begin
      seenAny  <= 1'b1;
      lastLead <= tsLead;
      if (tsLead) leadHeld <= tsTime;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!tsValid && !totValid)); // R9
  AST_FIRST_IS_LEAD: assert property (@(posedge clk) disable iff (rst)
    (tsValid && !seenAny) |-> tsLead); // R1
  AST_EDGE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (tsValid && seenAny) |-> (tsLead != lastLead)); // R1
  AST_EMIT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    locateStb |-> ##5 tsValid); // R7
  AST_NO_STRAY_EMIT: assert property (@(posedge clk) disable iff (rst)
    tsValid |-> $past(locateStb, 5)); // R5
  AST_TOT_ON_TRAIL: assert property (@(posedge clk) disable iff (rst)
    totValid |-> (tsValid && !tsLead)); // R6
  AST_TOT_VALUE: assert property (@(posedge clk) disable iff (rst)
    totValid |-> (totWidth == tsTime - leadHeld)); // R6
endmodule

bind tdcFineEncoder tdcFineEncoderChk #(.TW(TW)) chk_i (
  .clk(clk), .rst(rst), .locateStb(stb.locate),
  .tsValid(tsValid), .tsLead(tsLead), .tsTime(tsTime),
  .totValid(totValid), .totWidth(totWidth)
);

// File: tb/tdcFineEncoder_tb_top.sv
`timescale 1ns/1ps
module tdcFineEncoder_tb_top;
  localparam int TAPS = 64;
  localparam int CALW = 16;
  localparam int TW   = 32;
  localparam int P    = 5000;
  localparam int FCW  = $clog2(TAPS + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [TAPS-1:0] tapsIn = '0;
  logic            calWe = 1'b0;
  logic [FCW-1:0]  calAddr = '0;
  logic [CALW-1:0] calData = '0;
  logic            tsValid, tsLead, totValid;
  logic [TW-1:0]   tsTime, totWidth;

  always #2.5 clk = ~clk;

  tdcFineEncoder dut_i (
    .clk(clk), .rst(rst), .tapsIn(tapsIn), .calWe(calWe), .calAddr(calAddr),
    .calData(calData), .tsValid(tsValid), .tsLead(tsLead), .tsTime(tsTime),
    .totValid(totValid), .totWidth(totWidth)
  );

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int unsigned  calTab [TAPS+1];
  bit           refLevel = 1'b0;
  logic [TW-1:0] refLeadT = '0;

  bit            expV  [int];
  bit            expL  [int];
  logic [TW-1:0] expT  [int];
  bit            expTV [int];
  logic [TW-1:0] expW  [int];
  string         expTag[int];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareNow();
    bit ev = expV.exists(cyc) ? expV[cyc] : 1'b0;
    bit tv = expTV.exists(cyc) ? expTV[cyc] : 1'b0;
    string tg = expTag.exists(cyc) ? expTag[cyc] : "R5";
    chk(tsValid == ev, tg, "tsValid", tsValid, ev);
    chk(totValid == tv, tg, "totValid", totValid, tv);
    if (ev && tsValid) begin
      chk(tsLead == expL[cyc], tg, "tsLead", tsLead, expL[cyc]);
      chk(tsTime == expT[cyc], tg, "tsTime", tsTime, expT[cyc]);
    end
    if (tv && totValid)
      chk(totWidth == expW[cyc], tg, "totWidth", totWidth, expW[cyc]);
  endtask

  function automatic logic [TAPS-1:0] mkTaps(int k, bit nv, bit bub);
    logic [TAPS-1:0] v;
    for (int i = 0; i < TAPS; i++) v[i] = (i < k) ? nv : ~nv;
    if (bub) begin
      v[k-2] = ~nv;
      v[k+1] = nv;
    end
    return v;
  endfunction

  // k is the edge position known to the generator
  task automatic step(logic [TAPS-1:0] v, int k, string tag);
    int due;
    logic [TW-1:0] t;
    @(negedge clk);
    compareNow();
    calWe  = 1'b0;
    tapsIn = v;
    due = cyc + 6;
    expTag[due] = tag;
    if (v[0] != refLevel) begin
      refLevel = v[0];
      t = TW'(cyc) * TW'(P) - TW'(calTab[k]);
      expV[due] = 1'b1;
      expL[due] = refLevel;
      expT[due] = t;
      if (refLevel) refLeadT = t;
      else begin
        expTV[due] = 1'b1;
        expW[due]  = t - refLeadT;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step({TAPS{refLevel}}, 0, "R5");
  endtask

  task automatic calWrite(int a, int unsigned d);
    @(negedge clk);
    compareNow();
    tapsIn  = {TAPS{refLevel}};
    calWe   = 1'b1;
    calAddr = FCW'(a);
    calData = CALW'(d);
    calTab[a] = d;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tsValid == 1'b0, "R9", "tsValid in reset", tsValid, 0);
      chk(totValid == 1'b0, "R9", "totValid in reset", totValid, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(tsValid == 1'b0, "R9", "tsValid after reset", tsValid, 0);

    for (int i = 0; i <= TAPS; i++) calWrite(i, i * 71 + (i * i) % 13);
    idle(3);

    // R1 / R2: clean leading then trailing, R6 width
    step(mkTaps(10, 1'b1, 1'b0), 10, "R1");
    idle(3);
    step(mkTaps(40, 1'b0, 1'b0), 40, "R6");
    idle(4);

    // R4: window clamped at both ends
    step(mkTaps(1, 1'b1, 1'b0), 1, "R4");
    idle(2);
    step({TAPS{1'b0}}, TAPS, "R4");
    idle(4);

    // R3: bubble pairs in the transition
    step(mkTaps(30, 1'b1, 1'b1), 30, "R3");
    idle(2);
    step(mkTaps(50, 1'b0, 1'b1), 50, "R3");
    idle(4);

    // R10: tap 0 at current level, other taps disturbed
    step(64'hF0F0_0000_FF00_0000, 0, "R10");
    idle(6);
    step(mkTaps(20, 1'b1, 1'b0), 20, "R2");
    idle(1);
    step(64'h0F0F_00FF_0000_00F1, 0, "R10");
    idle(6);

    // R7: edges in consecutive snapshots
    step(mkTaps(5, 1'b0, 1'b0), 5, "R7");
    step(mkTaps(60, 1'b1, 1'b0), 60, "R7");
    step(mkTaps(33, 1'b0, 1'b0), 33, "R7");
    idle(6);

    // R8: recalibrated entry used by later edges
    calWrite(12, 3333);
    step(mkTaps(12, 1'b1, 1'b0), 12, "R8");
    idle(2);
    step(mkTaps(12, 1'b0, 1'b0), 12, "R8");
    idle(6);

    // R2: further positions
    for (int k = 3; k < TAPS; k += 14) begin
      step(mkTaps(k, 1'b1, 1'b0), k, "R2");
      idle(k % 3);
      step(mkTaps(TAPS - k, 1'b0, 1'b0), TAPS - k, "R2");
      idle(2);
    end
    idle(10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule